// File: doc/BRIEF.md
# Quarter-Wave Table Sine Oscillator

This block is a numerically controlled oscillator that emits one signed sine sample per enabled clock. A 32-bit phase register advances by a frequency word on every enabled clock and wraps naturally. The top twelve phase bits address a 1024-entry table that holds only the first quarter of a sine period. Mirroring the index and negating the value rebuild the other three quarters. The 14-bit amplitude is then rounded and saturated to a 12-bit converter code, which reaches the output after a fixed two-stage delay.

The output frequency is fcw × f_clk / 2^32, with fcw = round(f_out / f_clk × 2^32). For example, a 1.234 MHz tone from a 100 MHz clock needs fcw = 52999896. An optional dither adds a pseudo-random offset of 0 to 15 to the lookup phase. This breaks up the periodic spurs that come from truncating the phase. The dither never touches the stored accumulator.

Top module: `sine_nco`

## Requirements
- R1: On each rising clock edge with `en` high and `rst` low, `phase_out` becomes its previous value plus `fcw`, modulo 2^32. After reset, the first enabled edge therefore gives `phase_out` = `fcw`.
- R2: The lookup phase selects a quadrant q = bits[31:30] and an index i = bits[29:20]. The table is T[k] = round(8191·sin(k·π/2048)) for k = 0..1023. The amplitude is T[i] for q=0, T[1023−i] for q=1, −T[i] for q=2 and −T[1023−i] for q=3.
- R3: An amplitude v becomes the code floor((v+2)/4), so exact ties round toward positive infinity (v=2 gives 1, v=−2 gives 0).
- R4: A rounded result above 2047 is saturated to 2047. The negative peak −8191 gives −2048.
- R5: `dac_out` is the code of the lookup phase that was current two enabled edges earlier. Before two enabled edges have passed since reset, `dac_out` is 0.
- R6: While `en` is low, `phase_out` and `dac_out` hold their values, and `fcw` has no effect.
- R7: With `dith_en` high, the lookup phase is the accumulator plus d (0 ≤ d ≤ 15, from a free-running 16-bit LFSR), modulo 2^32. `phase_out` is not affected.
- R8: A synchronous reset sets `phase_out` and `dac_out` to 0 at the next edge and clears the delay stages.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Clock enable for accumulator and output delay |
| fcw | input | 32 | Frequency control word, added on each enabled edge |
| dith_en | input | 1 | Add 4-bit pseudo-random offset to lookup phase |
| phase_out | output | 32 | Current accumulator value |
| dac_out | output | 12 | Signed two's-complement converter code |

## Verification
A step of exactly a quarter turn lands the phase on each quadrant boundary. A wrong mirror rule then shows up as a 0 where 2047 belongs. Missing saturation would wrap the positive peak to −2048. The bench finds a table entry that sits on a rounding tie and places it in both a positive and a negative quadrant, where a truncating or round-half-away design is off by one. Wrap-around words, enable gaps with a changing `fcw`, and a mid-run reset expose an accumulator that leaks, a delay line that keeps stale samples, and an output lag of the wrong depth. Dithered runs must keep `phase_out` exact while each sample stays among the codes reachable from offsets 0 to 15.

// File: rtl/sine_nco.sv
module sine_nco #(
  parameter int PH_W  = 32,
  parameter int IDX_W = 10,
  parameter int AMP_W = 14,
  parameter int DAC_W = 12,
  parameter int DTH_W = 4,
  parameter int DLY   = 2,
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic [PH_W-1:0]         fcw,
  input  logic                    dith_en,
  output logic [PH_W-1:0]         phase_out,
  output logic signed [DAC_W-1:0] dac_out
);
  localparam int TOP_W  = IDX_W + 2;
  localparam int FRAC_W = PH_W - TOP_W;
  localparam int DEPTH  = 1 << IDX_W;
  localparam int AMAX   = (1 << (AMP_W - 1)) - 1;
  localparam int SHIFT  = AMP_W - DAC_W;
  localparam int RND    = 1 << (SHIFT - 1);
  localparam int CMAX   = (1 << (DAC_W - 1)) - 1;
  localparam real PI    = 3.141592653589793;

  logic [AMP_W-2:0] rom [DEPTH];
  initial begin
    for (int k = 0; k < DEPTH; k++)
      rom[k] = (AMP_W-1)'($rtoi(AMAX * $sin(k * PI / (2.0 * DEPTH)) + 0.5));
  end

  logic [PH_W-1:0]  acc;
  logic [15:0]      lfsr;
  logic [PH_W-1:0]  dval;
  logic [TOP_W-1:0] lk_top;
  logic [1:0]       quad;
  logic [IDX_W-1:0] idx, ridx;
  logic [AMP_W-2:0] mag;
  logic signed [AMP_W-1:0]       amp;
  logic signed [AMP_W:0]         rsum;
  logic signed [AMP_W-SHIFT:0]   rq;
  logic signed [DAC_W-1:0]       code;
  logic signed [DAC_W-1:0]       pipe [DLY];

  assign dval   = PH_W'(lfsr[DTH_W-1:0]) & {PH_W{dith_en}};
  assign lk_top = TOP_W'((acc + dval) >> FRAC_W);
  assign quad   = lk_top[TOP_W-1 -: 2];
  assign idx    = lk_top[IDX_W-1:0];
  assign ridx   = quad[0] ? ~idx : idx;
  assign mag    = rom[ridx];
  assign amp    = quad[1] ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
  assign rsum   = {amp[AMP_W-1], amp} + (AMP_W+1)'(RND);
  assign rq     = rsum[AMP_W:SHIFT];
  assign code   = (rq > CMAX) ? DAC_W'(CMAX) : rq[DAC_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) lfsr <= SEED;
    else     lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
      for (int s = 0; s < DLY; s++) pipe[s] <= '0;
    end else if (en) begin
      acc     <= acc + fcw;
      pipe[0] <= code;
      for (int s = 1; s < DLY; s++) pipe[s] <= pipe[s-1];
    end
  end

  assign phase_out = acc;
  assign dac_out   = pipe[DLY-1];
endmodule

// File: rtl/nco_chk.sv
module nco_chk #(
  parameter int PH_W  = 32,
  parameter int TOP_W = 12,
  parameter int DAC_W = 12
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    en,
  input logic [PH_W-1:0]         fcw,
  input logic [PH_W-1:0]         phase_out,
  input logic signed [DAC_W-1:0] dac_out,
  input logic [TOP_W-1:0]        lk_top,
  input logic signed [DAC_W-1:0] code
);
  // R1
  phase_step_chk: assert property (@(posedge clk) disable iff (rst)
    en |=> phase_out == $past(phase_out) + $past(fcw));

  // R6
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(phase_out) && $stable(dac_out));

  // R8
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> phase_out == '0 && dac_out == '0);

  // R2
  lower_half_sign_chk: assert property (@(posedge clk) disable iff (rst)
    lk_top[TOP_W-1] |-> code <= 0);

  // R2
  upper_half_sign_chk: assert property (@(posedge clk) disable iff (rst)
    !lk_top[TOP_W-1] |-> code >= 0);
endmodule

bind sine_nco nco_chk #(.PH_W(PH_W), .TOP_W(TOP_W), .DAC_W(DAC_W)) u_chk (
  .clk(clk), .rst(rst), .en(en), .fcw(fcw), .phase_out(phase_out),
  .dac_out(dac_out), .lk_top(lk_top), .code(code));

// File: tb/test_sine_nco.sv
module test_sine_nco;
  logic clk = 0, rst = 1, en = 0, dith_en = 0;
  logic [31:0] fcw = 0;
  logic [31:0] phase_out;
  logic signed [11:0] dac_out;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [31:0] m_acc, p1, p2;
  int d1, d2;
  bit f1, f2;

  sine_nco i_sine_nco (.clk(clk), .rst(rst), .en(en), .fcw(fcw),
    .dith_en(dith_en), .phase_out(phase_out), .dac_out(dac_out));

  always #10ns clk = ~clk;

  function automatic int lutv(int k);
    return $rtoi(8191.0 * $sin(k * 3.141592653589793 / 2048.0) + 0.5);
  endfunction

  function automatic int code_of(logic [31:0] p);
    int q, i, v, s, r;
    q = int'(p[31:30]);
    i = int'(p[29:20]);
    v = q[0] ? lutv(1023 - i) : lutv(i);
    if (q[1]) v = -v;
    s = v + 2;
    r = (s >= 0) ? s / 4 : -((-s + 3) / 4);
    if (r > 2047) r = 2047;
    return r;
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(string tag);
    bit ok;
    @(posedge clk);
    if (rst) begin
      m_acc = 0; p1 = 0; p2 = 0; d1 = 0; d2 = 0; f1 = 0; f2 = 0;
    end else if (en) begin
      d2 = d1; p2 = p1; f2 = f1;
      d1 = code_of(m_acc); p1 = m_acc; f1 = dith_en;
      m_acc = m_acc + fcw;
    end
    @(negedge clk);
    chk("R1 phase", phase_out, m_acc);
    if (f2) begin
      ok = 0;
      for (int d = 0; d < 16; d++) if (int'(dac_out) == code_of(p2 + 32'(d))) ok = 1;
      checks++;
      if (!ok) begin
        failures++;
        $display("FAIL R7 dither actual=%0d expected=%0d (+0..15)", dac_out, code_of(p2));
      end
    end else chk(tag, int'(dac_out), d2);
  endtask

  task automatic do_reset();
    rst = 1; en = 0; dith_en = 0; fcw = 0;
    tick("R8");
    tick("R8");
    rst = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R8 phase", phase_out, 0);
    chk("R8 dac", int'(dac_out), 0);
  endtask

  task automatic t_quadrants();
    do_reset();
    en = 1; fcw = 32'h4000_0000;
    for (int n = 0; n < 10; n++) tick("R2");
    do_reset();
    en = 1; fcw = 32'h4000_0000;
    tick("R5"); tick("R5"); tick("R5");
    chk("R4 positive peak", int'(dac_out), 2047);
    tick("R5");
    chk("R2 half turn", int'(dac_out), 0);
    tick("R5");
    chk("R4 negative peak", int'(dac_out), -2048);
  endtask

  task automatic t_tie();
    int kt = -1;
    for (int k = 1; k < 1024; k++) if (kt < 0 && (lutv(k) % 4) == 2) kt = k;
    do_reset();
    en = 1; fcw = 32'(kt) << 20;
    tick("R5"); tick("R5"); tick("R5");
    chk("R3 positive tie", int'(dac_out), (lutv(kt) + 2) / 4);
    do_reset();
    en = 1; fcw = 32'h8000_0000 | (32'(kt) << 20);
    tick("R5"); tick("R5"); tick("R5");
    chk("R3 negative tie", int'(dac_out), -((lutv(kt) - 2) / 4));
  endtask

  task automatic t_tone();
    do_reset();
    en = 1; fcw = 32'd52999896;
    for (int n = 0; n < 3000; n++) tick("R5");
  endtask

  task automatic t_wrap();
    do_reset();
    en = 1; fcw = 32'hF000_0001;
    for (int n = 0; n < 60; n++) tick("R1");
    fcw = 32'hFFFF_FFFF;
    for (int n = 0; n < 20; n++) tick("R1");
  endtask

  task automatic t_enable();
    logic [31:0] ph;
    logic signed [11:0] dv;
    do_reset();
    en = 1; fcw = 32'h0123_4567;
    for (int n = 0; n < 30; n++) tick("R5");
    ph = phase_out; dv = dac_out;
    en = 0;
    for (int n = 0; n < 6; n++) begin
      fcw = 32'(n) * 32'h1111_0000 + 32'h77;
      tick("R6");
      chk("R6 phase hold", phase_out, ph);
      chk("R6 dac hold", int'(dac_out), int'(dv));
    end
    en = 1; fcw = 32'h0123_4567;
    for (int n = 0; n < 30; n++) tick("R5");
    rst = 1;
    tick("R8");
    chk("R8 mid-run phase", phase_out, 0);
    chk("R8 mid-run dac", int'(dac_out), 0);
    rst = 0;
    tick("R8");
    chk("R1 first step", phase_out, 32'h0123_4567);
  endtask

  task automatic t_dither();
    do_reset();
    en = 1; dith_en = 1; fcw = 32'h000F_FFF3;
    for (int n = 0; n < 600; n++) tick("R7");
    dith_en = 0;
    for (int n = 0; n < 40; n++) tick("R7");
  endtask

  initial begin
    t_reset();
    t_quadrants();
    t_tie();
    t_tone();
    t_wrap();
    t_enable();
    t_dither();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20ns * 150000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule